// File: doc/BRIEF.md
# Movable Sprite Position and Scan Unit

This unit places one 8-pixel sprite on a scanline and turns it into a one-bit pixel enable. The horizontal position is held in a 6-bit linear-feedback counter that steps once every four motion ticks and comes back to its start state every 40 steps. That gives a period of 160 ticks, the same as the number of visible pixels on a line. A motion tick is any clock in which the visible-area enable or the extra stuffed pulse is high. While neither is high, the counter and its quarter-step phase hold exactly where they are. Because of this, the line's blanking interval does not move the sprite. Each stuffed pulse moves it one pixel left.

Fixed decodes of the counter state launch drawing of up to four copies: a main copy once per period, and close, medium and far copies selected by a 3-bit copy mode. A launch starts a 3-bit binary scan counter that walks the sprite's bits. The scan counter can be stretched to 2 or 4 ticks per bit. It is never reset by a launch, so a copy that starts near the right edge continues on the next line. The graphics byte is double-buffered: a write to the partner sprite copies the current byte into a delayed one, and a delay select picks which byte is shown. A mirror bit reverses the bit order at once.

Top module: `sprite_pos_unit`

## Requirements
- R1: While rst_n is low, pix_en is 0. Reset clears the position counter, its phase and the scan counter, so that after reset the main copy is first drawn exactly as after a position reset (R3).
- R2: Only clocks with motion_en or stuff_pulse high count as ticks. On any other clock, position, phase, pending launch, scan address and pix_en all hold.
- R3: Number the ticks after a position reset from 0. The main copy's pixel p (p = 0..7, at 1x width) is visible in the cycle after tick 159+p, and it repeats every 160 ticks.
- R4: Extra copies start at tick 15 (close), 31 (medium) and 63 (far), each repeating every 160 ticks. Close is enabled for copy_mode 001 and 011. Medium is enabled for 011, 010 and 110. Far is enabled for 100 and 110. Modes 000, 101 and 111 give the main copy only.
- R5: pos_reset clears the position and phase but does not launch a copy. With copy_mode 000, nothing is visible for ticks 0 to 158.
- R6: width_sel 00 shows each bit for 1 tick, 01 for 2 ticks and 1x (10 or 11) for 4 ticks. Pixel p of a copy launched at tick s is visible after ticks s+w*p through s+w*p+w-1.
- R7: A launch that arrives while a copy is still being drawn, up to and including the tick on which its last bit ends, is ignored. The scan address is not restarted.
- R8: Pixel p shows graphics bit 7-p when mirror is 0 and bit p when mirror is 1. The mirror bit is applied immediately.
- R9: gfx_wr loads gfx_data into the current byte. partner_wr copies the current byte (its value before any write in the same clock) into the delayed byte. vdelay=1 shows the delayed byte and vdelay=0 shows the current byte.
- R10: Each stuffed pulse given while motion_en is low advances the position by one tick, so k pulses move every copy k ticks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| motion_en | input | 1 | High during the visible part of the line |
| stuff_pulse | input | 1 | Extra motion tick used for leftward adjustment |
| pos_reset | input | 1 | Clears position counter and phase |
| copy_mode | input | 3 | Selects close, medium and far copies |
| width_sel | input | 2 | Stretch: 00 1x, 01 2x, 1x 4x |
| mirror | input | 1 | Reverse the bit order of the sprite |
| vdelay | input | 1 | Show the delayed byte instead of the current one |
| gfx_wr | input | 1 | Load gfx_data into the current byte |
| partner_wr | input | 1 | Copy the current byte into the delayed byte |
| gfx_data | input | GFX_W | Graphics byte |
| pix_en | output | 1 | Sprite pixel enable |

## Verification
Every result is due a fixed number of ticks after a position reset. A launch decoded at phase 2 of the copy's count is latched on that tick, and the scan starts on the next tick. The first pixel is therefore seen in the cycle after tick 15, 31, 63 or 159. Graphics, mirror and delay-select changes reach pix_en in the same cycle as the scan address they apply to. The bench drives every input at the falling edge and samples pix_en at the next falling edge, after each tick. It compares pix_en to the bit predicted from the tick number. On idle clocks it checks that the value has not moved.

// File: rtl/sprite_pos_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the sprite position unit: counter width, the
// feedback step of the position counter and the copy-mode decode.
// Assumes the counter state that counts as 0 is all zeros.
package sprite_pos_pkg;

    localparam int LFSR_W = 6;

    typedef enum logic [1:0] {
        WID_X1  = 2'd0,
        WID_X2  = 2'd1,
        WID_X4  = 2'd2,
        WID_X4B = 2'd3
    } width_e;

    // One step of the XNOR-feedback shift sequence.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {~(s[0] ^ s[1]), s[LFSR_W-1:1]};
    endfunction

    // Counter state reached after n steps from the all-zero state.
    function automatic logic [LFSR_W-1:0] lfsr_at(input int n);
        logic [LFSR_W-1:0] s;
        s = '0;
        for (int i = 0; i < n; i++) s = lfsr_step(s);
        return s;
    endfunction

    // Extra copies enabled by a mode, as {far, medium, close}.
    function automatic logic [2:0] copy_enables(input logic [2:0] mode);
        logic [2:0] en;
        en[0] = (mode == 3'b001) || (mode == 3'b011);
        en[1] = (mode == 3'b011) || (mode == 3'b010) || (mode == 3'b110);
        en[2] = (mode == 3'b100) || (mode == 3'b110);
        return en;
    endfunction

endpackage

// File: rtl/sprite_pos_counter.sv
`timescale 1ns/1ps
// Position counter: a 2-bit phase divider and a feedback shift counter
// that steps on every fourth motion tick and wraps after PERIOD counts.
// Assumes tick already merges the visible-area and stuffed pulses.
module sprite_pos_counter
    import sprite_pos_pkg::*;
#(
    parameter int PERIOD = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pos_clr,
    output logic [1:0]        phase,
    output logic [LFSR_W-1:0] state
);
    localparam logic [LFSR_W-1:0] WRAP_ST = lfsr_at(PERIOD - 1);
    localparam logic [LFSR_W-1:0] BAD_ST  = '1;

    logic [LFSR_W-1:0] next_st;

    // Next count: wrap at the last count, escape the lock-up state.
    always_comb begin
        if (state == WRAP_ST || state == BAD_ST) next_st = '0;
        else                                     next_st = lfsr_step(state);
    end

    // Phase advances per tick; the counter steps when phase leaves 3.
    always_ff @(posedge clk) begin
        if (!rst_n || pos_clr) begin
            phase <= 2'd0;
            state <= '0;
        end else if (tick) begin
            phase <= phase + 2'd1;
            if (phase == 2'd3) state <= next_st;
        end
    end
endmodule

// File: rtl/sprite_copy_decode.sv
`timescale 1ns/1ps
// Launch decode: compares the counter against the main and the three
// optional copy positions on phase 2 and latches a launch for one tick.
// Assumes a position clear also drops any pending launch.
module sprite_copy_decode
    import sprite_pos_pkg::*;
#(
    parameter int PERIOD   = 40,
    parameter int CLOSE_AT = 3,
    parameter int MED_AT   = 7,
    parameter int FAR_AT   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pos_clr,
    input  logic [1:0]        phase,
    input  logic [LFSR_W-1:0] state,
    input  logic [2:0]        copy_mode,
    output logic              launch
);
    localparam logic [LFSR_W-1:0] MAIN_ST = lfsr_at(PERIOD - 1);

    function automatic int copy_pos(input int g);
        case (g)
            0:       return CLOSE_AT;
            1:       return MED_AT;
            default: return FAR_AT;
        endcase
    endfunction

    logic [2:0] en;
    logic [2:0] copy_hit;
    logic       hit;

    assign en = copy_enables(copy_mode);

    // One comparator per optional copy.
    for (genvar g = 0; g < 3; g++) begin : g_copy
        localparam logic [LFSR_W-1:0] COPY_ST = lfsr_at(copy_pos(g));
        assign copy_hit[g] = en[g] && (state == COPY_ST);
    end

    // Decode is qualified by phase 2 so the launch lands on phase 3.
    always_comb hit = (phase == 2'd2) && ((state == MAIN_ST) || (|copy_hit));

    // Launch latch, updated on ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n || pos_clr) launch <= 1'b0;
        else if (tick)         launch <= hit;
    end
endmodule

// File: rtl/sprite_scan.sv
`timescale 1ns/1ps
// Scan counter: binary bit address that runs once through the sprite
// after a launch, stretched to 1, 2 or 4 ticks per bit.
// Assumes a launch while running is ignored; only rst_n clears it.
module sprite_scan
    import sprite_pos_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              launch,
    input  logic [1:0]        phase,
    input  logic [1:0]        width_sel,
    output logic              scan_on,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    logic adv;

    // Stretch gate: every tick, odd phases, or phase 3 only.
    always_comb begin
        case (width_e'(width_sel))
            WID_X1:  adv = 1'b1;
            WID_X2:  adv = phase[0];
            default: adv = (phase == 2'd3);
        endcase
    end

    // Run through all bits once; stop when the last bit is passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_on <= 1'b0;
            addr    <= '0;
        end else if (tick) begin
            if (scan_on) begin
                if (adv) begin
                    addr <= addr + 1'b1;
                    if (addr == LAST) scan_on <= 1'b0;
                end
            end else if (launch) begin
                scan_on <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sprite_gfx_buf.sv
`timescale 1ns/1ps
// Graphics store: current and delayed bytes, delay select and mirror
// select, producing the pixel bit for the scan address.
// Assumes the scan address is held at zero while no copy is drawn.
module sprite_gfx_buf #(
    parameter int GFX_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_own,
    input  logic              wr_partner,
    input  logic [GFX_W-1:0]  wdata,
    input  logic              vdelay,
    input  logic              mirror,
    input  logic              scan_on,
    input  logic [ADDR_W-1:0] addr,
    output logic [GFX_W-1:0]  cur_q,
    output logic [GFX_W-1:0]  dly_q,
    output logic              pix
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(GFX_W - 1);

    logic [GFX_W-1:0]  shown;
    logic [ADDR_W-1:0] idx;

    // Current byte takes writes; delayed byte takes the partner copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            dly_q <= '0;
        end else begin
            if (wr_own)     cur_q <= wdata;
            if (wr_partner) dly_q <= cur_q;
        end
    end

    // Select byte and bit order, gated by an active scan.
    always_comb begin
        shown = vdelay ? dly_q : cur_q;
        idx   = mirror ? addr : (LAST - addr);
        pix   = scan_on && shown[idx];
    end
endmodule

// File: rtl/sprite_pos_unit.sv
`timescale 1ns/1ps
// Movable sprite position and scan unit: merges motion and stuffed
// ticks, runs the position counter, decodes copy launches, scans the
// graphics and outputs the pixel enable.
// Assumes all inputs are synchronous to the pixel clock.
module sprite_pos_unit
    import sprite_pos_pkg::*;
#(
    parameter int GFX_W    = 8,
    parameter int PERIOD   = 40,
    parameter int CLOSE_AT = 3,
    parameter int MED_AT   = 7,
    parameter int FAR_AT   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             motion_en,
    input  logic             stuff_pulse,
    input  logic             pos_reset,
    input  logic [2:0]       copy_mode,
    input  logic [1:0]       width_sel,
    input  logic             mirror,
    input  logic             vdelay,
    input  logic             gfx_wr,
    input  logic             partner_wr,
    input  logic [GFX_W-1:0] gfx_data,
    output logic             pix_en
);
    localparam int ADDR_W = $clog2(GFX_W);

    logic              tick;
    logic [1:0]        phase;
    logic [LFSR_W-1:0] pstate;
    logic              launch;
    logic              scan_on;
    logic [ADDR_W-1:0] scan_addr;
    logic [GFX_W-1:0]  cur_q;
    logic [GFX_W-1:0]  dly_q;

    // Any motion source advances the object by one tick.
    assign tick = motion_en || stuff_pulse;

    sprite_pos_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pos_clr(pos_reset),
        .phase(phase), .state(pstate)
    );

    sprite_copy_decode #(
        .PERIOD(PERIOD), .CLOSE_AT(CLOSE_AT), .MED_AT(MED_AT), .FAR_AT(FAR_AT)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pos_clr(pos_reset),
        .phase(phase), .state(pstate), .copy_mode(copy_mode), .launch(launch)
    );

    sprite_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .launch(launch),
        .phase(phase), .width_sel(width_sel),
        .scan_on(scan_on), .addr(scan_addr)
    );

    sprite_gfx_buf #(.GFX_W(GFX_W), .ADDR_W(ADDR_W)) u_gfx (
        .clk(clk), .rst_n(rst_n), .wr_own(gfx_wr), .wr_partner(partner_wr),
        .wdata(gfx_data), .vdelay(vdelay), .mirror(mirror),
        .scan_on(scan_on), .addr(scan_addr),
        .cur_q(cur_q), .dly_q(dly_q), .pix(pix_en)
    );
endmodule

// File: rtl/sprite_pos_unit_chk.sv
`timescale 1ns/1ps
// Protocol checker for the sprite position unit, bound to the top.
module sprite_pos_unit_chk
    import sprite_pos_pkg::*;
#(
    parameter int GFX_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              pos_reset,
    input logic              partner_wr,
    input logic [1:0]        phase,
    input logic [LFSR_W-1:0] pstate,
    input logic              launch,
    input logic              scan_on,
    input logic [ADDR_W-1:0] scan_addr,
    input logic [GFX_W-1:0]  cur_q,
    input logic [GFX_W-1:0]  dly_q,
    input logic              pix_en
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pos_reset) |=> ($stable(phase) && $stable(pstate) && $stable(scan_addr) && $stable(scan_on)));

    // R5
    pos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_reset |=> (phase == 2'd0 && pstate == '0 && !launch));

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pstate != '1);

    // R3
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_on) |-> (scan_addr == '0));

    // R7
    scan_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_on) |-> ($past(scan_addr) == '1 && scan_addr == '0));

    // R9
    delay_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partner_wr |=> (dly_q == $past(cur_q)));

    // R1
    pix_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> scan_on);
endmodule

bind sprite_pos_unit sprite_pos_unit_chk #(.GFX_W(GFX_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos_reset(pos_reset),
    .partner_wr(partner_wr), .phase(phase), .pstate(pstate), .launch(launch),
    .scan_on(scan_on), .scan_addr(scan_addr), .cur_q(cur_q), .dly_q(dly_q),
    .pix_en(pix_en)
);

// File: tb/sprite_pos_unit_tb.sv
`timescale 1ns/1ps
module sprite_pos_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       motion_en = 1'b0;
    logic       stuff_pulse = 1'b0;
    logic       pos_reset = 1'b0;
    logic [2:0] copy_mode = 3'd0;
    logic [1:0] width_sel = 2'd0;
    logic       mirror = 1'b0;
    logic       vdelay = 1'b0;
    logic       gfx_wr = 1'b0;
    logic       partner_wr = 1'b0;
    logic [7:0] gfx_data = 8'h00;
    logic       pix_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sprite_pos_unit u_dut (
        .clk(clk), .rst_n(rst_n), .motion_en(motion_en), .stuff_pulse(stuff_pulse),
        .pos_reset(pos_reset), .copy_mode(copy_mode), .width_sel(width_sel),
        .mirror(mirror), .vdelay(vdelay), .gfx_wr(gfx_wr), .partner_wr(partner_wr),
        .gfx_data(gfx_data), .pix_en(pix_en)
    );

    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] wid;
        logic       mir;
        logic       vd;
        logic [7:0] nv;
        logic [7:0] ov;
        logic [1:0] gap;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 2'd0, 1'b0, 1'b0, 8'hA5, 8'h00, 2'd0},
        '{3'b001, 2'd0, 1'b0, 1'b0, 8'hC3, 8'h00, 2'd0},
        '{3'b011, 2'd0, 1'b1, 1'b0, 8'h81, 8'h00, 2'd0},
        '{3'b010, 2'd1, 1'b0, 1'b0, 8'hF1, 8'h00, 2'd0},
        '{3'b100, 2'd0, 1'b0, 1'b1, 8'h3C, 8'hE7, 2'd0},
        '{3'b110, 2'd2, 1'b0, 1'b0, 8'hFF, 8'h00, 2'd0},
        '{3'b011, 2'd3, 1'b1, 1'b0, 8'h96, 8'h00, 2'd0},
        '{3'b000, 2'd0, 1'b0, 1'b0, 8'h5A, 8'h00, 2'd2},
        '{3'b111, 2'd1, 1'b0, 1'b1, 8'h00, 8'hB7, 2'd0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R3/R5";
            1: return "R4";
            2: return "R4/R8";
            3: return "R4/R6";
            4: return "R4/R9";
            5: return "R6/R7";
            6: return "R7/R8";
            7: return "R2";
            default: return "R4/R9/R6";
        endcase
    endfunction

    // Expected pixel after tick j (ticks counted from a position reset).
    function automatic logic exp_pix(input int j, input logic [2:0] mode,
                                     input logic [1:0] wid, input logic mir,
                                     input logic [7:0] b);
        int w;
        int len;
        int base[4];
        logic ok[4];
        int last;
        w = (wid == 2'd0) ? 1 : (wid == 2'd1) ? 2 : 4;
        len = 8 * w;
        base = '{15, 31, 63, 159};
        ok[0] = (mode == 3'b001) || (mode == 3'b011);
        ok[1] = (mode == 3'b011) || (mode == 3'b010) || (mode == 3'b110);
        ok[2] = (mode == 3'b100) || (mode == 3'b110);
        ok[3] = 1'b1;
        last = -1000;
        for (int n = 0; n < 2; n++) begin
            for (int c = 0; c < 4; c++) begin
                int s;
                s = base[c] + 160 * n;
                if (ok[c] && s > last + len) begin
                    last = s;
                    if (j >= s && j < s + len) begin
                        int p;
                        p = (j - s) / w;
                        return mir ? b[p] : b[7 - p];
                    end
                end
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag, input int where);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at tick %0d: pix_en=%0b expected %0b", tag, where, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_tick();
        motion_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        motion_en = 1'b0;
    endtask

    task automatic clear_pos();
        pos_reset = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pos_reset = 1'b0;
    endtask

    task automatic load_gfx(input logic [7:0] oldv, input logic [7:0] newv);
        gfx_wr = 1'b1; gfx_data = oldv;
        @(posedge clk); @(negedge clk);
        gfx_wr = 1'b0; partner_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        partner_wr = 1'b0; gfx_wr = 1'b1; gfx_data = newv;
        @(posedge clk); @(negedge clk);
        gfx_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: output low during reset, even with ticks running
        motion_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            chk(pix_en, 1'b0, "R1", i);
        end
        motion_en = 1'b0;
        rst_n = 1'b1;
        gfx_wr = 1'b1; gfx_data = 8'hFF;
        @(posedge clk); @(negedge clk);
        gfx_wr = 1'b0;
        // R1: counter starts from zero after reset, main copy at tick 159
        for (int j = 0; j < 168; j++) begin
            do_tick();
            if (j == 158 || j == 159 || j == 166 || j == 167)
                chk(pix_en, (j >= 159 && j <= 166), "R1", j);
        end
        copy_mode = 3'b000;
        for (int j = 0; j < 40; j++) do_tick();

        // Table of vectors
        for (int v = 0; v < NV; v++) begin
            load_gfx(VECS[v].ov, VECS[v].nv);
            copy_mode = VECS[v].mode;
            width_sel = VECS[v].wid;
            mirror    = VECS[v].mir;
            vdelay    = VECS[v].vd;
            clear_pos();
            for (int j = 0; j < 200; j++) begin
                logic e;
                e = exp_pix(j, VECS[v].mode, VECS[v].wid, VECS[v].mir,
                            VECS[v].vd ? VECS[v].ov : VECS[v].nv);
                do_tick();
                chk(pix_en, e, vec_tag(v), j);
                for (int g = 0; g < int'(VECS[v].gap); g++) begin
                    idle(1);
                    chk(pix_en, e, "R2", j);
                end
            end
            copy_mode = 3'b000;
            for (int j = 0; j < 40; j++) do_tick();
        end
        mirror = 1'b0; vdelay = 1'b0; width_sel = 2'd0; copy_mode = 3'b000;

        // R10: four stuffed pulses while blank move the copy 4 ticks earlier
        gfx_wr = 1'b1; gfx_data = 8'hFF;
        @(posedge clk); @(negedge clk);
        gfx_wr = 1'b0;
        clear_pos();
        stuff_pulse = 1'b1;
        idle(4);
        stuff_pulse = 1'b0;
        for (int j = 0; j < 170; j++) begin
            do_tick();
            if (j == 154 || j == 155 || j == 162 || j == 163)
                chk(pix_en, (j >= 155 && j <= 162), "R10", j);
        end
        for (int j = 0; j < 40; j++) do_tick();

        // R9: write and partner copy in the same clock keep the old current byte
        gfx_wr = 1'b1; gfx_data = 8'h11;
        @(posedge clk); @(negedge clk);
        partner_wr = 1'b1; gfx_data = 8'h88;
        @(posedge clk); @(negedge clk);
        gfx_wr = 1'b0; partner_wr = 1'b0;
        vdelay = 1'b1;
        clear_pos();
        for (int j = 0; j < 168; j++) begin
            do_tick();
            if (j >= 158)
                chk(pix_en, exp_pix(j, 3'b000, 2'd0, 1'b0, 8'h11), "R9", j);
        end
        vdelay = 1'b0;
        chk(pix_en, 1'b0, "R9", 168);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule